// File: doc/BRIEF.md
# Reversible-Gate Synchronous Binary Up Counter

This block is a binary up counter whose stages all sit on one clock edge. Every bit is a toggle register. It keeps its value when its toggle input is low and inverts it when that input is high. The toggle inputs come from a chain of three-input controlled-AND cells. Each cell has its third input fixed at 0, so it acts as a plain two-input AND. A two-output copy cell (controlled-XOR against a constant 0) duplicates every state bit that drives more than one load.

The count advances by one on each rising clock edge while the enable is high. From the all-ones value it wraps to zero. The unused outputs of the reversible cells are brought out on a garbage bus, so the whole network stays a one-to-one mapping. The width is a parameter and defaults to four bits.

Top module: `rsync_upcnt`

## Requirements
- R1: A synchronous active-high reset sets every count bit to 0 at the next rising clock edge.
- R2: With enable low, the count keeps its value across clock edges.
- R3: With enable high, the count after each edge equals the previous count plus 1, modulo 2^WIDTH.
- R4: With enable high, the count steps from 2^WIDTH-1 (all ones, 15 at the default width) to 0.
- R5: Bit k toggles on an edge exactly when enable is high and every bit below k is 1; otherwise bit k holds.
- R6: The garbage bus is a registered copy of the reversible cells' pass-through outputs, taken at the same edge. For k = 0..WIDTH-2, bit 2k is the chain's control input to stage k+1, and bit 2k+1 is the copied state bit Q[k]. Bit 2(WIDTH-1) is Q[WIDTH-1]. All garbage bits are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stages |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable |
| count | output | WIDTH | Counter value |
| garbage | output | 2*WIDTH-1 | Registered unused outputs of the reversible cells |

## Verification
The hardest event to reach from the ports is the full carry ripple at the wrap from all ones to zero. It is harder still when enable drops exactly at the all-ones value, because then the long AND chain must hold every bit. The stimulus runs long enabled stretches so the count reaches 15 many times. Directed passes then stop enable at 15, and at values whose low bits are all ones, and check both the hold and the later wrap. Random enable patterns with a fixed seed cover the remaining carry patterns and are checked against a bench model of previous count plus enable.

// File: rtl/rsync_pkg.sv
package rsync_pkg;
  typedef struct packed {
    logic p;
    logic q;
  } fey_out_t;

  typedef struct packed {
    logic p;
    logic q;
    logic r;
  } tof_out_t;
endpackage

// File: rtl/rsync_feynman.sv
module rsync_feynman
  import rsync_pkg::*;
(
  input  logic     a,
  input  logic     b,
  output fey_out_t o
);
  always_comb begin
    o.p = a;
    o.q = a ^ b;
  end
endmodule

// File: rtl/rsync_toffoli.sv
module rsync_toffoli
  import rsync_pkg::*;
(
  input  logic     a,
  input  logic     b,
  input  logic     c,
  output tof_out_t o
);
  always_comb begin
    o.p = a;
    o.q = b;
    o.r = (a & b) ^ c;
  end
endmodule

// File: rtl/rsync_tstage.sv
module rsync_tstage (
  input  logic clk,
  input  logic rst,
  input  logic t,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else if (t) q <= ~q;
  end

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !t |=> $stable(q)); // R5
  AST_STAGE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    t |=> (q != $past(q))); // R5
endmodule

// File: rtl/rsync_upcnt.sv
module rsync_upcnt
  import rsync_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  output logic [WIDTH-1:0]   count,
  output logic [2*WIDTH-2:0] garbage
);
  localparam int GW = 2*WIDTH-1;
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] tog;
  logic [GW-1:0]    garb_c;

  assign tog[0] = en;

  genvar k;
  generate
    for (k = 0; k < WIDTH; k++) begin : g_stage
      rsync_tstage u_ff (.clk(clk), .rst(rst), .t(tog[k]), .q(q[k]));
      if (k < WIDTH-1) begin : g_chain
        fey_out_t fo;
        tof_out_t to;
        // copy Q[k]: one copy for the output, one for the AND chain
        rsync_feynman u_fan (.a(q[k]), .b(1'b0), .o(fo));
        rsync_toffoli u_and (.a(tog[k]), .b(fo.q), .c(1'b0), .o(to));
        assign tog[k+1]      = to.r;
        assign garb_c[2*k]   = to.p;
        assign garb_c[2*k+1] = to.q;
      end else begin : g_last
        assign garb_c[2*k] = q[k];
      end
    end
  endgenerate

  assign count = q;

  always_ff @(posedge clk) begin
    if (rst) garbage <= '0;
    else     garbage <= garb_c;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (count == '0)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count)); // R2
  AST_INCREMENT: assert property (@(posedge clk) disable iff (rst)
    en |=> (count == $past(count) + 1'b1)); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && count == ALL_ONES) |=> (count == '0)); // R4
  AST_GARB_RESET: assert property (@(posedge clk)
    rst |=> (garbage == '0)); // R6
endmodule

// File: tb/rsync_upcnt_test.sv
`timescale 1ns/1ps
module rsync_upcnt_test;
  localparam int WIDTH = 4;
  localparam int GW = 2*WIDTH-1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [WIDTH-1:0] count;
  logic [GW-1:0]    garbage;
  int n_chk = 0;
  int n_bad = 0;
  logic [WIDTH-1:0] model;

  rsync_upcnt #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rst(rst), .en(en), .count(count), .garbage(garbage));

  always #5 clk = ~clk;

  function automatic logic [WIDTH-1:0] next_val(logic [WIDTH-1:0] c, logic e);
    return c + {{(WIDTH-1){1'b0}}, e};
  endfunction

  function automatic logic [GW-1:0] garb_val(logic [WIDTH-1:0] c, logic e);
    logic [GW-1:0] g;
    logic t;
    t = e;
    for (int k = 0; k < WIDTH-1; k++) begin
      g[2*k]   = t;
      g[2*k+1] = c[k];
      t = t & c[k];
    end
    g[2*(WIDTH-1)] = c[WIDTH-1];
    return g;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one edge with given enable; checks count and garbage after it
  task automatic step(logic e, string req);
    logic [GW-1:0] g_exp;
    en = e;
    g_exp = garb_val(model, e);
    @(posedge clk);
    #2;
    model = next_val(model, e);
    check(req, count, model);
    check("R6", garbage, g_exp);
  endtask

  initial begin
    model = '0;
    repeat (2) @(posedge clk);
    #2;
    check("R1", count, 0);
    check("R1/R6", garbage, 0);
    @(negedge clk);
    rst = 1'b0;
    // R2: hold with enable low
    for (int i = 0; i < 3; i++) step(1'b0, "R2");
    // R3/R4: run through full cycle twice
    for (int i = 0; i < 2*(1<<WIDTH); i++)
      step(1'b1, (model == '1) ? "R4" : "R3");
    // R5: stop at all-ones and at low-bits-all-ones patterns
    while (model != '1) step(1'b1, "R3");
    step(1'b0, "R5");
    step(1'b0, "R5");
    step(1'b1, "R4");
    while (model != 4'd7) step(1'b1, "R3");
    step(1'b0, "R5");
    step(1'b1, "R5");
    // random enables
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) step(1'(($urandom % 4) != 0), "R3");
    // R1: reset mid-count
    while (model == '0) step(1'b1, "R3");
    rst = 1'b1;
    en = 1'b1;
    @(posedge clk);
    #2;
    model = '0;
    check("R1", count, 0);
    check("R6", garbage, 0);
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, "R3");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule